// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen serial transfers on its own. The host first fills a small shared memory over a simple synchronous bus. The memory holds one command byte per queue slot, one transmit word per slot, and one receive word per slot. The host sets the first and last slot indices and then starts the run. The controller walks the slots in ascending order. For each slot it reads the command, shifts the transmit word out on the serial data output, collects the same number of bits from the serial data input into the receive word, and records the slot as completed.

After the last slot finishes, the controller raises a sticky done flag, drops its running state and waits. If the host has enabled interrupts, the interrupt output follows the done flag. The controller only reads the transmit and command slots, so one set of commands can be run any number of times.

Top module: `spi_queue_master`

## Requirements
- R1: Byte address map, big-endian within each 16-bit word (the even byte holds bits 15:8):
  - receive word i is at 2i;
  - transmit word i is at 0x20+2i;
  - command byte i is at 0x40+i;
  - control register at 0x50 (bit0 run, which reads 1 while the queue is running; bit1 interrupt enable);
  - first index at 0x51, last index at 0x52, clock divisor at 0x53, bit count at 0x54;
  - status at 0x55 (bit7 done, bits 3:0 completed pointer).

  `hostSize` selects the access width: 0 is a byte, 1 is a word (address rounded down to even), 2 is a long word made of four bytes (address rounded down to a multiple of 4). Data is right-justified in the data buses.
- R2: Writing 1 to control bit0 while idle runs the slots from the first index upward, each slot exactly once and in order. Control bit0 reads 1 from the cycle after the write until the run ends.
- R3: Command byte fields: bit7 keeps the chip select asserted into the next slot; bit6 selects the programmed bit count (when clear the transfer is 8 bits); bits 3:0 are driven on `csN` for the whole transfer. `csN` is 4'hF when no run is active.
- R4: The programmed bit count is clamped to the range 8 to 16. A value below 8 gives 8 and a value above 16 gives 16.
- R5: Each transfer sends the low n bits of the transmit word MSB first. `mosi` changes only while `sck` falls, and `miso` is captured as `sck` rises. `sck` stays high and low for max(divisor/2, 1) clock cycles each, and it is low whenever no run is active.
- R6: The receive word holds the n received bits right-justified, with the first received bit in bit n-1. All bits above bit n-1 are written as zero.
- R7: The completed pointer holds the index of the most recently stored slot.
- R8: When the last slot is stored, the done flag sets in the same cycle that the run bit clears. Writing a status byte with bit7 set clears the done flag. `irq` is high exactly when the done flag and the interrupt enable are both set.
- R9: The controller never changes the transmit or command slots. They read back as the host wrote them after any number of runs.
- R10: The run stops at the last index or at slot 15, whichever comes first. It never wraps to slot 0.
- R11: Between two slots where the first has bit7 clear, `csN` returns to 4'hF for at least one cycle. When bit7 is set, `csN` goes directly from one slot's pattern to the next slot's pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host access strobe |
| hostWr | input | 1 | Host access is a write |
| hostSize | input | 2 | Access width: 0 byte, 1 word, 2 long word |
| hostAddr | input | 7 | Byte address |
| hostWrData | input | 32 | Write data, right-justified |
| hostRdData | output | 32 | Combinational read data, right-justified |
| irq | output | 1 | Queue-finished interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Chip-select pattern, 4'hF when idle |

## Verification
- Host reads are combinational. The bench sets the address at a falling clock edge and samples one time step later.
- A host write takes effect at the next rising edge. The run bit therefore reads 1 at the following falling edge.
- Serial data is collected by a scoreboard monitor one time step after each `sck` rise, and no shift can happen at that point. Expected words are pushed by the driver before the run starts.
- Receive words, the status byte and `irq` are due in the cycle after the final slot store. The bench polls the status byte until the done flag appears and only then reads results, so no check depends on an exact latency the requirements do not fix.

// File: rtl/spi_queue_pkg.sv
package spi_queue_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CS_W = 4;
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_FIRST = 3'd1;
  localparam logic [2:0] REG_LAST  = 3'd2;
  localparam logic [2:0] REG_DIV   = 3'd3;
  localparam logic [2:0] REG_BITS  = 3'd4;
  localparam logic [2:0] REG_STAT  = 3'd5;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic store;
    logic csRelease;
    logic finish;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_LOAD, SEQ_LOW, SEQ_HIGH, SEQ_STORE
  } seqState_e;

  typedef enum logic [2:0] {
    AREA_RX, AREA_TX, AREA_CMD, AREA_REG, AREA_NONE
  } hostArea_e;
endpackage

// File: rtl/spi_queue_ctrl.sv
module spi_queue_ctrl
  import spi_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [IDX_W-1:0] firstIdx,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic [DIV_W-1:0] halfLen,
  input  logic [CNT_W-1:0] curBits,
  input  logic             curHold,
  output seqStrobe_t       seqStb,
  output logic [IDX_W-1:0] slotIdx,
  output logic             busy,
  output logic             shifting,
  output logic             sckOut
);
  seqState_e state;
  logic [DIV_W-1:0] halfCnt;
  logic [CNT_W-1:0] bitCnt;
  logic halfDone, lastBit, lastSlot;

  assign halfDone = (halfCnt == halfLen - 1'b1);
  assign lastBit  = (bitCnt == curBits - 1'b1);
  assign lastSlot = (slotIdx == lastIdx) || (slotIdx == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      slotIdx <= '0;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (startReq) begin
          slotIdx <= firstIdx;
          state   <= SEQ_LOAD;
        end
        SEQ_LOAD: begin
          halfCnt <= '0;
          bitCnt  <= '0;
          state   <= SEQ_LOW;
        end
        SEQ_LOW: begin
          if (halfDone) begin
            halfCnt <= '0;
            state   <= SEQ_HIGH;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        SEQ_HIGH: begin
          if (halfDone) begin
            halfCnt <= '0;
            if (lastBit) begin
              state <= SEQ_STORE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= SEQ_LOW;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        SEQ_STORE: begin
          if (lastSlot) begin
            state <= SEQ_IDLE;
          end else begin
            slotIdx <= slotIdx + 1'b1;
            state   <= SEQ_LOAD;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    seqStb           = '0;
    seqStb.load      = (state == SEQ_LOAD);
    seqStb.sample    = (state == SEQ_LOW) && halfDone;
    seqStb.shift     = (state == SEQ_HIGH) && halfDone && !lastBit;
    seqStb.store     = (state == SEQ_STORE);
    seqStb.finish    = (state == SEQ_STORE) && lastSlot;
    seqStb.csRelease = (state == SEQ_STORE) && (lastSlot || !curHold);
  end

  assign busy     = (state != SEQ_IDLE);
  assign shifting = (state == SEQ_LOW) || (state == SEQ_HIGH);
  assign sckOut   = (state == SEQ_HIGH);
endmodule

// File: rtl/spi_queue_datapath.sv
module spi_queue_datapath
  import spi_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TX_BASE = 2 * DEPTH,
  localparam int CMD_BASE = 4 * DEPTH,
  localparam int REG_BASE = 5 * DEPTH,
  localparam int ADDR_W = $clog2(REG_BASE + 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  input  seqStrobe_t        seqStb,
  input  logic [IDX_W-1:0]  slotIdx,
  input  logic              busy,
  input  logic              shifting,
  input  logic              miso,
  output logic              startReq,
  output logic [IDX_W-1:0]  firstIdx,
  output logic [IDX_W-1:0]  lastIdx,
  output logic [DIV_W-1:0]  halfLen,
  output logic [CNT_W-1:0]  curBits,
  output logic              curHold,
  output logic              mosi,
  output logic [CS_W-1:0]   csN,
  output logic              doneFlag,
  output logic              irqEn
);
  logic [DATA_W-1:0] rxRam  [DEPTH];
  logic [DATA_W-1:0] txRam  [DEPTH];
  logic [7:0]        cmdRam [DEPTH];

  logic [DIV_W-1:0]  divReg;
  logic [CNT_W-1:0]  bitsReg;
  logic [IDX_W-1:0]  donePtr;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  // host lane decode: up to four byte lanes per access
  logic [2:0]        nBytes;
  logic [ADDR_W-1:0] baseAddr;
  logic [31:0]       wrAligned;
  hostArea_e         laneArea [4];
  logic [IDX_W-1:0]  laneIdx  [4];
  logic              laneLow  [4];
  logic [2:0]        laneReg  [4];
  logic              laneWe   [4];
  logic [7:0]        laneData [4];
  logic [7:0]        rdByte   [4];

  always_comb begin
    case (hostSize)
      2'd0:    nBytes = 3'd1;
      2'd1:    nBytes = 3'd2;
      default: nBytes = 3'd4;
    endcase
    baseAddr  = hostAddr & ~ADDR_W'(nBytes - 3'd1);
    wrAligned = hostWrData << (8 * (4 - nBytes));
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [ADDR_W-1:0] laneAddr;
    logic [ADDR_W-1:0] off;
    always_comb begin
      laneAddr    = baseAddr + ADDR_W'(k);
      laneData[k] = wrAligned[31-8*k -: 8];
      laneWe[k]   = hostSel && hostWr && (3'(k) < nBytes);
      laneReg[k]  = '0;
      laneLow[k]  = 1'b0;
      laneIdx[k]  = '0;
      off         = '0;
      if (laneAddr < ADDR_W'(TX_BASE)) begin
        laneArea[k] = AREA_RX;
        off         = laneAddr;
        laneIdx[k]  = off[IDX_W:1];
        laneLow[k]  = off[0];
      end else if (laneAddr < ADDR_W'(CMD_BASE)) begin
        laneArea[k] = AREA_TX;
        off         = laneAddr - ADDR_W'(TX_BASE);
        laneIdx[k]  = off[IDX_W:1];
        laneLow[k]  = off[0];
      end else if (laneAddr < ADDR_W'(REG_BASE)) begin
        laneArea[k] = AREA_CMD;
        off         = laneAddr - ADDR_W'(CMD_BASE);
        laneIdx[k]  = off[IDX_W-1:0];
      end else if (laneAddr <= ADDR_W'(REG_BASE + 5)) begin
        laneArea[k] = AREA_REG;
        off         = laneAddr - ADDR_W'(REG_BASE);
        laneReg[k]  = off[2:0];
      end else begin
        laneArea[k] = AREA_NONE;
      end
    end

    always_comb begin
      case (laneArea[k])
        AREA_RX:  rdByte[k] = laneLow[k] ? rxRam[laneIdx[k]][7:0] : rxRam[laneIdx[k]][15:8];
        AREA_TX:  rdByte[k] = laneLow[k] ? txRam[laneIdx[k]][7:0] : txRam[laneIdx[k]][15:8];
        AREA_CMD: rdByte[k] = cmdRam[laneIdx[k]];
        AREA_REG: begin
          case (laneReg[k])
            REG_CTRL:  rdByte[k] = {6'b0, irqEn, busy};
            REG_FIRST: rdByte[k] = 8'(firstIdx);
            REG_LAST:  rdByte[k] = 8'(lastIdx);
            REG_DIV:   rdByte[k] = 8'(divReg);
            REG_BITS:  rdByte[k] = 8'(bitsReg);
            REG_STAT:  rdByte[k] = {doneFlag, 7'(donePtr)};
            default:   rdByte[k] = 8'h00;
          endcase
        end
        default:  rdByte[k] = 8'h00;
      endcase
    end
  end

  always_comb begin
    case (nBytes)
      3'd1:    hostRdData = {24'b0, rdByte[0]};
      3'd2:    hostRdData = {16'b0, rdByte[0], rdByte[1]};
      default: hostRdData = {rdByte[0], rdByte[1], rdByte[2], rdByte[3]};
    endcase
  end

  always_comb begin
    startReq = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (laneWe[k] && laneArea[k] == AREA_REG && laneReg[k] == REG_CTRL && laneData[k][0])
        startReq = 1'b1;
    end
    startReq = startReq && !busy;
  end

  // transfer length and clock half-period derived from host registers
  logic [CNT_W-1:0] progBits, slotBits;
  logic [DIV_W-1:0] divHalf;

  always_comb begin
    if (bitsReg < CNT_W'(8))           progBits = CNT_W'(8);
    else if (bitsReg > CNT_W'(DATA_W)) progBits = CNT_W'(DATA_W);
    else                               progBits = bitsReg;
    slotBits = cmdRam[slotIdx][6] ? progBits : CNT_W'(8);
    divHalf  = divReg >> 1;
    halfLen  = (divHalf == '0) ? DIV_W'(1) : divHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        rxRam[i]  <= '0;
        txRam[i]  <= '0;
        cmdRam[i] <= '0;
      end
      divReg   <= DIV_W'(4);
      bitsReg  <= CNT_W'(8);
      firstIdx <= '0;
      lastIdx  <= '0;
      irqEn    <= 1'b0;
      doneFlag <= 1'b0;
      donePtr  <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      curBits  <= CNT_W'(8);
      curHold  <= 1'b0;
      csN      <= '1;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (laneWe[k]) begin
          case (laneArea[k])
            AREA_RX: begin
              if (laneLow[k]) rxRam[laneIdx[k]][7:0]  <= laneData[k];
              else            rxRam[laneIdx[k]][15:8] <= laneData[k];
            end
            AREA_TX: begin
              if (laneLow[k]) txRam[laneIdx[k]][7:0]  <= laneData[k];
              else            txRam[laneIdx[k]][15:8] <= laneData[k];
            end
            AREA_CMD: cmdRam[laneIdx[k]] <= laneData[k];
            AREA_REG: begin
              case (laneReg[k])
                REG_CTRL:  irqEn    <= laneData[k][1];
                REG_FIRST: firstIdx <= laneData[k][IDX_W-1:0];
                REG_LAST:  lastIdx  <= laneData[k][IDX_W-1:0];
                REG_DIV:   divReg   <= laneData[k][DIV_W-1:0];
                REG_BITS:  bitsReg  <= laneData[k][CNT_W-1:0];
                REG_STAT:  if (laneData[k][7]) doneFlag <= 1'b0;
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end

      if (seqStb.load) begin
        txShift <= txRam[slotIdx] << (CNT_W'(DATA_W) - slotBits);
        rxShift <= '0;
        curBits <= slotBits;
        curHold <= cmdRam[slotIdx][7];
        csN     <= cmdRam[slotIdx][CS_W-1:0];
      end
      if (seqStb.sample) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (seqStb.shift)  txShift <= txShift << 1;
      if (seqStb.store) begin
        rxRam[slotIdx] <= rxShift;
        donePtr        <= slotIdx;
      end
      if (seqStb.csRelease) csN <= '1;
      if (seqStb.finish) doneFlag <= 1'b1;
    end
  end

  assign mosi = shifting && txShift[DATA_W-1];
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import spi_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ADDR_W = $clog2(5 * DEPTH + 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   csN
);
  seqStrobe_t       seqStb;
  logic [IDX_W-1:0] slotIdx, firstIdx, lastIdx;
  logic [DIV_W-1:0] halfLen;
  logic [CNT_W-1:0] curBits;
  logic             curHold, busy, shifting, startReq, doneFlag, irqEn;

  spi_queue_ctrl #(.DEPTH(DEPTH), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .firstIdx(firstIdx),
    .lastIdx(lastIdx), .halfLen(halfLen), .curBits(curBits), .curHold(curHold),
    .seqStb(seqStb), .slotIdx(slotIdx), .busy(busy), .shifting(shifting),
    .sckOut(sck)
  );

  spi_queue_datapath #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostSize(hostSize), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .seqStb(seqStb), .slotIdx(slotIdx), .busy(busy),
    .shifting(shifting), .miso(miso), .startReq(startReq), .firstIdx(firstIdx),
    .lastIdx(lastIdx), .halfLen(halfLen), .curBits(curBits), .curHold(curHold),
    .mosi(mosi), .csN(csN), .doneFlag(doneFlag), .irqEn(irqEn)
  );

  assign irq = doneFlag && irqEn;
endmodule

// File: rtl/spi_queue_chk.sv
module spi_queue_chk (
  input logic clk,
  input logic rstN,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic doneFlag,
  input logic storeStb
);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sck && !mosi));

  // R5
  mosi_hold_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi));

  // R8
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !busy);

  // R8
  done_after_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(storeStb));

  // R2
  run_starts_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !sck);
endmodule

bind spi_queue_master spi_queue_chk chk_i (
  .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .busy(busy),
  .doneFlag(doneFlag), .storeStb(seqStb.store)
);

// File: tb/spi_queue_master_tb_top.sv
`timescale 1ns/100ps
module spi_queue_master_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0;
  logic [1:0] hostSize = 2'd0;
  logic [6:0] hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic irq, sck, mosi, miso;
  logic [3:0] csN;

  always #2.5 clk = ~clk;

  spi_queue_master dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostSize(hostSize), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso),
    .csN(csN)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // serial slave: deterministic bit stream, advanced on each sck fall
  function automatic bit pat(int i);
    return ((i * 5 + 3) % 7) > 2;
  endfunction
  int misoIdx = 0;
  assign miso = pat(misoIdx);
  always @(negedge sck) if (rstN) misoIdx = misoIdx + 1;

  // chip-select release counter and sck high-width meter
  logic [3:0] prevCs = 4'hF;
  int csGaps = 0, hiRun = 0, lastHigh = 0;
  always @(posedge clk) begin
    if (rstN && prevCs != 4'hF && csN == 4'hF) csGaps++;
    prevCs = csN;
    if (sck) hiRun++;
    else if (hiRun != 0) begin lastHigh = hiRun; hiRun = 0; end
  end

  // scoreboard
  typedef struct {
    logic [3:0]  cs;
    int          n;
    logic [15:0] tx;
  } xfer_t;
  xfer_t expQ[$];
  int gotBits = 0;

  initial begin : monitorProc
    xfer_t cur;
    logic [15:0] w;
    logic csOk;
    w = '0; csOk = 1'b1;
    cur.cs = '0; cur.n = 0; cur.tx = '0;
    forever begin
      @(posedge sck); #1;
      if (!rstN) continue;
      if (gotBits == 0) begin
        if (expQ.size() == 0) begin
          check("R2", "unexpected transfer", 1, 0);
          continue;
        end
        cur = expQ.pop_front();
        w = '0; csOk = 1'b1;
      end
      w = {w[14:0], mosi};
      if (csN !== cur.cs) csOk = 1'b0;
      gotBits++;
      if (gotBits == cur.n) begin
        check("R5", "mosi word MSB first", w, cur.tx);
        check("R3", "csN pattern during transfer", csOk, 1);
        gotBits = 0;
      end
    end
  end

  // bench model of host-visible contents
  logic [7:0]  cmdM [16];
  logic [15:0] txM [16];
  logic [15:0] rxM [16];
  int expBase = 0;

  task automatic hwr(int a, int sz, logic [31:0] d);
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = a[6:0]; hostSize = sz[1:0]; hostWrData = d;
    @(negedge clk);
    hostSel = 0; hostWr = 0;
  endtask

  task automatic hrd(int a, int sz, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a[6:0]; hostSize = sz[1:0]; hostSel = 1; hostWr = 0;
    #1 d = hostRdData;
    hostSel = 0;
  endtask

  task automatic setSlot(int i, logic [7:0] cmd, logic [15:0] tx);
    cmdM[i] = cmd; txM[i] = tx;
    hwr(8'h40 + i, 0, {24'b0, cmd});
    hwr(2 * i, 1, 32'hFFFF);          // stale receive content, overwritten by the run
    hwr(8'h20 + 2 * i, 1, {16'b0, tx});
  endtask

  // pushes the expected transfer for slot i and derives its receive word
  task automatic expectSlot(int i, int progBits);
    xfer_t x;
    logic [15:0] rv;
    int n;
    n = cmdM[i][6] ? progBits : 8;
    x.cs = cmdM[i][3:0];
    x.n = n;
    x.tx = txM[i] & 16'((32'd1 << n) - 1);
    expQ.push_back(x);
    rv = '0;
    for (int j = 0; j < n; j++) rv = {rv[14:0], pat(expBase + j)};
    expBase += n;
    rxM[i] = rv;
  endtask

  task automatic runQueue(int first, int last, int progBits, bit irqOn);
    logic [31:0] d;
    int i;
    i = first;
    forever begin
      expectSlot(i, progBits);
      if (i == last || i == 15) break;
      i++;
    end
    hwr(8'h51, 0, first);
    hwr(8'h52, 0, last);
    csGaps = 0;
    hwr(8'h50, 0, {30'b0, irqOn, 1'b1});
    hrd(8'h50, 0, d);
    check("R2", "run bit reads 1 while running", d[0], 1);
    d = '0;
    while (!d[7]) begin
      repeat (8) @(posedge clk);
      hrd(8'h55, 0, d);
    end
    check("R2", "all queued transfers issued", expQ.size(), 0);
    check("R2", "no partial transfer left", gotBits, 0);
    hrd(8'h50, 0, d);
    check("R8", "run bit cleared at done", d[0], 0);
  endtask

  initial begin : mainProc
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // reset state
    check("R3", "csN idle after reset", csN, 4'hF);
    check("R5", "sck low after reset", sck, 0);
    check("R8", "irq low after reset", irq, 0);
    hrd(8'h55, 0, d); check("R7", "status after reset", d, 0);
    hrd(8'h50, 0, d); check("R1", "control after reset", d, 0);
    hrd(8'h53, 0, d); check("R1", "divisor after reset", d, 4);

    // scenario A: mixed lengths, hold on slot 2, interrupts enabled
    hwr(8'h53, 0, 4);
    hwr(8'h54, 0, 12);
    setSlot(0, 8'h4E, 16'h0ABC);
    setSlot(1, 8'h0D, 16'h1234);
    setSlot(2, 8'hCB, 16'hF5A5);
    setSlot(3, 8'h07, 16'h00C3);
    runQueue(0, 3, 12, 1);
    hrd(8'h55, 0, d); check("R7", "status done with pointer 3", d, 8'h83);
    check("R8", "irq with enable set", irq, 1);
    for (int i = 0; i < 4; i++) begin
      hrd(2 * i, 1, d); check("R6", "receive word right-justified", d, rxM[i]);
    end
    hrd(8'h02, 0, d); check("R6", "unused upper bits of 8-bit slot zero", d, 0);
    hrd(8'h00, 2, d); check("R1", "long read of slots 0 and 1", d, {rxM[0], rxM[1]});
    hrd(8'h03, 0, d); check("R1", "byte read low half of slot 1", d, rxM[1][7:0]);
    check("R11", "csN releases only after non-hold slots", csGaps, 3);
    check("R5", "sck high width with divisor 4", lastHigh, 2);
    hrd(8'h20, 1, d); check("R9", "transmit slot 0 unchanged", d, txM[0]);
    hrd(8'h42, 0, d); check("R9", "command slot 2 unchanged", d, cmdM[2]);
    hwr(8'h55, 0, 8'h80);
    hrd(8'h55, 0, d); check("R8", "done cleared by write of 1", d, 8'h03);
    check("R8", "irq drops with done", irq, 0);

    // scenario B: bit count clamp high, divisor 6, interrupts off
    hwr(8'h53, 0, 6);
    hwr(8'h54, 0, 20);
    setSlot(5, 8'h43, 16'hBEEF);
    runQueue(5, 5, 16, 0);
    hrd(8'h0A, 1, d); check("R4", "16-bit clamp receive word", d, rxM[5]);
    check("R5", "sck high width with divisor 6", lastHigh, 3);
    check("R8", "irq stays low without enable", irq, 0);
    hrd(8'h55, 0, d); check("R7", "status pointer 5", d, 8'h85);
    hwr(8'h55, 0, 8'h80);

    // scenario C: bit count clamp low
    hwr(8'h54, 0, 3);
    setSlot(6, 8'h42, 16'h5A3C);
    runQueue(6, 6, 8, 0);
    hrd(8'h0C, 1, d); check("R4", "8-bit clamp receive word", d, rxM[6]);
    hrd(8'h0C, 0, d); check("R6", "8-bit clamp upper byte zero", d, 0);
    hwr(8'h55, 0, 8'h80);

    // scenario D: last index below first index, divisor 2
    hwr(8'h53, 0, 2);
    setSlot(14, 8'h05, 16'h0099);
    setSlot(15, 8'h8A, 16'h0077);
    runQueue(14, 2, 8, 1);
    hrd(8'h55, 0, d); check("R10", "stop at slot 15", d, 8'h8F);
    hrd(8'h1C, 2, d); check("R10", "slots 14 and 15 received", d, {rxM[14], rxM[15]});
    hrd(8'h00, 1, d); check("R10", "slot 0 untouched, no wrap", d, rxM[0]);
    check("R11", "release after slot 14 and at end", csGaps, 2);
    check("R5", "sck high width with divisor 2", lastHigh, 1);
    check("R3", "csN idle after run", csN, 4'hF);
    hrd(8'h3E, 1, d); check("R9", "transmit slot 15 unchanged", d, txM[15]);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule